// File: doc/BRIEF.md
# Logic Self-Test Wrapper

This block places built-in self-test hardware around a small 8-bit combinational circuit under test. In normal operation the circuit is fed from the primary inputs, and its outputs pass straight to the primary outputs. When `test_mode` is high, an input multiplexer feeds the circuit from an on-chip pseudo-random pattern generator instead. A `start` pulse launches a self-test run of fixed length. During the run, one pattern is applied per functional clock and each response is folded into a multiple-input signature register.

At the end of the run, the accumulated signature is compared with a reference value. The reference is computed at elaboration from the fault-free circuit and the pattern count. The block then raises `done` and reports good or faulty on `pass`. Both outputs hold until the next accepted start.

A set of fault-injection pins lets a testbench force any single output bit of the circuit under test to a stuck value. This shows that the comparison catches a defective circuit.

Top module: `lbist_wrap`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `pass` are all 0.
- R2: With `test_mode` low, `po` equals the circuit function of `pi` in the same cycle. The function of an 8-bit input x is: bits [3:0] = (x[3:0] + x[7:4]) mod 16, and bits [7:4] = (x[7:4] AND NOT x[3:0]) XOR {x[2:0], x[3]}.
- R3: With `test_mode` high during a run, the circuit is fed from the pattern generator. The generator is an 8-bit left-shifting register. Its new bit 0 is the XOR of bits 7, 5, 4 and 3. Its seed is 8'h01. In the first run cycle, `po` is the circuit function of 8'h01.
- R4: `start` is accepted only when `test_mode` is high and no run is in progress. A `start` with `test_mode` low leaves `busy` and `done` unchanged.
- R5: An accepted run keeps `busy` high for exactly N_PAT cycles, applying N_PAT successive generator states. `done` rises two clock edges after `busy` last went high was sampled (one compare cycle), and `busy` and `done` are never high together.
- R6: The signature register is cleared to zero at the start of every run. For each run cycle, its next value is {sig[6:0], sig[7]^sig[5]^sig[4]^sig[3]} XOR the circuit output. Repeated runs therefore give identical results.
- R7: A fault-free run ends with `pass` = 1.
- R8: With `flt_en` high, output bit `flt_bit` of the circuit under test is forced to `flt_val`. A run under a stuck fault that changes the signature ends with `pass` = 0.
- R9: `done` and `pass` hold their values until the next accepted start. A `start` during a run has no effect on its length or result.
- R10: In normal mode, an injected fault is visible on `po` at bit `flt_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | 1 selects the pattern generator as the circuit's source |
| start | input | 1 | Launches a self-test run |
| pi | input | 8 | Primary inputs |
| flt_en | input | 1 | Enables stuck-at fault injection |
| flt_val | input | 1 | Stuck value for the injected fault |
| flt_bit | input | 3 | Output bit of the circuit to force |
| po | output | 8 | Primary outputs (circuit response) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result valid |
| pass | output | 1 | 1 = signature matched the reference |

## Verification
Two functions can fall in the same cycle. A new `start` can arrive while a run is still compacting. It can also arrive in the very cycle the finished result is being held. The bench pulses `start` in the middle of a run and checks that the run still lasts exactly N_PAT cycles with the expected verdict. It then restarts directly from the done state and checks that the signature register is cleared, so the second verdict equals the first. A scoreboard pairs each launched run with a verdict computed by an independent model of the generator, circuit and compactor.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int W    = 8;
    localparam int SELW = $clog2(W);

    localparam logic [W-1:0] SEED = 8'h01;
    // feedback taps at bits 7,5,4,3 : x^8 + x^6 + x^5 + x^4 + 1
    localparam logic [W-1:0] TAPS = 8'hB8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_CMP,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic            en;
        logic            val;
        logic [SELW-1:0] sel;
    } flt_t;

    function automatic logic [W-1:0] lfsr_step(input logic [W-1:0] s);
        return {s[W-2:0], ^(s & TAPS)};
    endfunction

    function automatic logic [W-1:0] cut_fn(input logic [W-1:0] x);
        logic [3:0] lo;
        logic [3:0] hi;
        lo = x[3:0] + x[7:4];
        hi = (x[7:4] & ~x[3:0]) ^ {x[2:0], x[3]};
        return {hi, lo};
    endfunction

    function automatic logic [W-1:0] misr_step(input logic [W-1:0] m,
                                               input logic [W-1:0] r);
        return {m[W-2:0], ^(m & TAPS)} ^ r;
    endfunction

    function automatic logic [W-1:0] golden_sig(input int n);
        logic [W-1:0] s;
        logic [W-1:0] m;
        s = SEED;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m = misr_step(m, cut_fn(s));
            s = lfsr_step(s);
        end
        return m;
    endfunction

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg
    import lbist_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    output logic [W-1:0] pat
);

    always_ff @(posedge clk) begin
        if (rst || load) pat <= SEED;
        else if (adv)    pat <= lfsr_step(pat);
    end

endmodule

// File: rtl/lbist_cut.sv
module lbist_cut
    import lbist_pkg::*;
(
    input  logic [W-1:0] x,
    input  flt_t         flt,
    output logic [W-1:0] y
);

    logic [W-1:0] good;

    always_comb begin
        good = cut_fn(x);
        y    = good;
        if (flt.en) y[flt.sel] = flt.val;
    end

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
    import lbist_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] resp,
    output logic [W-1:0] sig
);

    always_ff @(posedge clk) begin
        if (rst || clr) sig <= '0;
        else if (en)    sig <= misr_step(sig, resp);
    end

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int N_PAT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic test_mode,
    input  logic sig_ok,
    output logic launch,
    output logic running,
    output logic done,
    output logic pass
);

    localparam int CW = $clog2(N_PAT + 1);

    st_e           st;
    logic [CW-1:0] cnt;

    assign launch  = start && test_mode && (st == ST_IDLE || st == ST_DONE);
    assign running = (st == ST_RUN);
    assign done    = (st == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            pass <= 1'b0;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: begin
                    if (launch) begin
                        st   <= ST_RUN;
                        cnt  <= '0;
                        pass <= 1'b0;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(N_PAT - 1)) st <= ST_CMP;
                end
                ST_CMP: begin
                    pass <= sig_ok;
                    st   <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lbist_wrap.sv
module lbist_wrap
    import lbist_pkg::*;
#(
    parameter int           N_PAT   = 100,
    parameter logic [W-1:0] REF_SIG = golden_sig(N_PAT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            test_mode,
    input  logic            start,
    input  logic [W-1:0]    pi,
    input  logic            flt_en,
    input  logic            flt_val,
    input  logic [SELW-1:0] flt_bit,
    output logic [W-1:0]    po,
    output logic            busy,
    output logic            done,
    output logic            pass
);

    logic [W-1:0] pat;
    logic [W-1:0] cut_in;
    logic [W-1:0] cut_out;
    logic [W-1:0] misr_q;
    logic         launch;
    flt_t         flt;

    assign flt    = '{en: flt_en, val: flt_val, sel: flt_bit};
    assign cut_in = test_mode ? pat : pi;
    assign po     = cut_out;

    lbist_ctrl #(.N_PAT(N_PAT)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .test_mode (test_mode),
        .sig_ok    (misr_q == REF_SIG),
        .launch    (launch),
        .running   (busy),
        .done      (done),
        .pass      (pass)
    );

    lbist_prpg i_prpg (
        .clk  (clk),
        .rst  (rst),
        .load (launch),
        .adv  (busy),
        .pat  (pat)
    );

    lbist_cut i_cut (
        .x   (cut_in),
        .flt (flt),
        .y   (cut_out)
    );

    lbist_misr i_misr (
        .clk  (clk),
        .rst  (rst),
        .clr  (launch),
        .en   (busy),
        .resp (cut_out),
        .sig  (misr_q)
    );

endmodule

// File: rtl/lbist_wrap_chk.sv
module lbist_wrap_chk
    import lbist_pkg::*;
#(
    parameter int N_PAT = 100
) (
    input logic         clk,
    input logic         rst,
    input logic         test_mode,
    input logic         start,
    input logic [W-1:0] pi,
    input logic [W-1:0] cut_in,
    input logic [W-1:0] misr_q,
    input logic         busy,
    input logic         done,
    input logic         pass
);

    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_cnt <= 0;
        else              run_cnt <= run_cnt + 1;
    end

    a_r2_bypass_path: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> cut_in == pi);

    a_r3_gen_nonzero: assert property (@(posedge clk) disable iff (rst)
        (test_mode && busy) |-> cut_in != '0);

    a_r5_run_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_cnt == N_PAT);

    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    a_r6_sig_cleared: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> misr_q == '0);

    a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
        (done && !(start && test_mode)) |=> (done && $stable(pass)));

endmodule

bind lbist_wrap lbist_wrap_chk #(.N_PAT(N_PAT)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .start     (start),
    .pi        (pi),
    .cut_in    (cut_in),
    .misr_q    (misr_q),
    .busy      (busy),
    .done      (done),
    .pass      (pass)
);

// File: tb/test_lbist_wrap.sv
module test_lbist_wrap;

    localparam int N = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       test_mode = 1'b0;
    logic       start = 1'b0;
    logic [7:0] pi = 8'h00;
    logic       flt_en = 1'b0;
    logic       flt_val = 1'b0;
    logic [2:0] flt_bit = 3'd0;
    logic [7:0] po;
    logic       busy;
    logic       done;
    logic       pass;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit exp_q[$];
    int runs_seen = 0;

    always #2.5 clk = ~clk;

    lbist_wrap #(.N_PAT(N)) i_lbist_wrap (
        .clk(clk), .rst(rst), .test_mode(test_mode), .start(start), .pi(pi),
        .flt_en(flt_en), .flt_val(flt_val), .flt_bit(flt_bit),
        .po(po), .busy(busy), .done(done), .pass(pass)
    );

    // ---- independent reference model ----
    function automatic int m_cut(input int x);
        int a, b, lo, hi, rot;
        a   = x & 15;
        b   = (x >> 4) & 15;
        lo  = (a + b) % 16;
        rot = ((a << 1) & 14) | ((a >> 3) & 1);
        hi  = (b & (~a & 15)) ^ rot;
        return hi * 16 + lo;
    endfunction

    function automatic int m_shift(input int s);
        int fb;
        fb = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
        return ((s << 1) & 255) | fb;
    endfunction

    function automatic int m_force(input int y, input bit en, input bit v, input int b);
        if (!en) return y;
        return v ? (y | (1 << b)) : (y & ~(1 << b) & 255);
    endfunction

    function automatic int m_sig(input bit en, input bit v, input int b);
        int s, m;
        s = 1;
        m = 0;
        for (int i = 0; i < N; i++) begin
            m = m_shift(m) ^ m_force(m_cut(s), en, v, b);
            s = m_shift(s);
        end
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---- monitor: run length and verdict scoreboard ----
    int  bcnt = 0;
    bit  prev_busy = 1'b0;
    bit  prev_done = 1'b0;
    always @(negedge clk) begin
        if (busy) bcnt++;
        if (prev_busy && !busy) begin
            chk(bcnt == N, "R5 run length", bcnt, N);
            bcnt = 0;
        end
        if (!prev_done && done) begin
            chk(!busy, "R5 busy low at done", busy, 0);
            if (exp_q.size() == 0) chk(1'b0, "R7 unexpected verdict", pass, 0);
            else begin
                bit e;
                e = exp_q.pop_front();
                chk(pass == e, "R7/R8 verdict", pass, e);
            end
            runs_seen++;
        end
        prev_busy = busy;
        prev_done = done;
    end

    // ---- driver ----
    task automatic launch_run(input bit en, input bit v, input int b, input bit poke);
        int ref_sig, sig, tmo;
        ref_sig = m_sig(1'b0, 1'b0, 0);
        sig     = m_sig(en, v, b);
        flt_en  = en;
        flt_val = v;
        flt_bit = 3'(b);
        test_mode = 1'b1;
        exp_q.push_back(sig == ref_sig);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R5 busy after start", busy, 1);
        if (!en) chk(po == 8'(m_cut(1)), "R3 first pattern response", po, m_cut(1));
        if (poke) begin
            repeat (N / 2) @(negedge clk);
            start = 1'b1;  // R9: ignored mid-run
            @(negedge clk);
            start = 1'b0;
        end
        tmo = 0;
        while (!done && tmo < 4 * N) begin
            @(negedge clk);
            tmo++;
        end
        chk(done == 1'b1, "R5 done reached", done, 1);
    endtask

    task automatic hold_check(input int cycles);
        bit p0;
        p0 = pass;
        pi = 8'h5A;
        repeat (cycles) @(negedge clk);
        chk(done && pass == p0, "R9 result held", pass, p0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pass, "R1 reset state", {busy, done, pass}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !pass, "R1 after reset release", {busy, done, pass}, 0);

        // R2 normal-mode bypass over several patterns
        for (int v = 0; v < 256; v += 37) begin
            pi = 8'(v);
            #1;
            chk(po == 8'(m_cut(v)), "R2 normal mode function", po, m_cut(v));
        end
        pi = 8'hFF; #1;
        chk(po == 8'(m_cut(255)), "R2 normal mode all ones", po, m_cut(255));

        // R10 fault visible on po
        pi = 8'h3C; flt_en = 1'b1; flt_val = 1'b1; flt_bit = 3'd6; #1;
        chk(po == 8'(m_force(m_cut(8'h3C), 1'b1, 1'b1, 6)), "R10 stuck-at-1 on po", po,
            m_force(m_cut(8'h3C), 1'b1, 1'b1, 6));
        flt_val = 1'b0; flt_bit = 3'd0; #1;
        chk(po == 8'(m_force(m_cut(8'h3C), 1'b1, 1'b0, 0)), "R10 stuck-at-0 on po", po,
            m_force(m_cut(8'h3C), 1'b1, 1'b0, 0));
        flt_en = 1'b0;

        // R4 start ignored in normal mode
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy && !done, "R4 start ignored without test mode", {busy, done}, 0);

        // R7 fault-free run, then R9 hold
        launch_run(1'b0, 1'b0, 0, 1'b0);
        hold_check(7);
        // R6 restart straight from done, with a mid-run start (R9)
        launch_run(1'b0, 1'b0, 0, 1'b1);
        hold_check(3);
        // R8 stuck faults
        launch_run(1'b1, 1'b0, 0, 1'b0);
        hold_check(2);
        launch_run(1'b1, 1'b1, 7, 1'b0);
        launch_run(1'b1, 1'b1, 3, 1'b0);
        // back to fault-free: R6 cleared signature
        launch_run(1'b0, 1'b0, 0, 1'b0);
        @(negedge clk);
        chk(runs_seen == 6, "R5 verdict count", runs_seen, 6);
        chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule